// File: doc/BRIEF.md
# External Interrupt Pin Sense Unit

This block sits between four external interrupt pins and a central interrupt controller. Each pin is brought into the clock domain through a two-flop synchroniser. It is then judged against its own sense mode: active-high level, rising edge, falling edge or active-low level. An edge sets a per-pin latch that holds the request until software clears it. A level request follows the synchronised pin directly.

A single 32-bit control word sets up all four pins. It holds the four sense modes, a per-pin enable, a master enable for the whole external group and a critical-routing select. The same word also carries write-one-to-clear bits for the edge latches. Software configures the unit and clears edge requests through a simple write strobe. The word reads back combinationally, so a read-modify-write keeps the sense modes intact. Each pin's request is forwarded only when its own enable and the master enable are both set.

Top module: `extint_sense`

## Requirements
- R1: After a synchronous active-low reset, the control word reads 0, every request output is 0 and `crit_route` is 0.
- R2: The control word places pin n's 2-bit sense mode at bits [23-2n:22-2n], pin n's enable at bit 11-n, the master enable at bit 12 and critical routing at bit 0. Every other bit, including the clear bits 27:24, reads back as 0.
- R3: In sense mode 0 (active-high level), an enabled pin's request is 1 while the synchronised pin is high and 0 once it is low. The request follows the pin two clocks later and latches nothing.
- R4: In sense mode 3 (active-low level), an enabled pin's request is 1 while the synchronised pin is low and 0 while it is high.
- R5: In sense mode 1 (rising edge), a low-to-high transition sets the pin's latch. The request stays 1 after the pin returns low, and a falling transition does not set it.
- R6: In sense mode 2 (falling edge), a high-to-low transition sets the latch. A rising transition does not set it.
- R7: A control write with bit 27-n set clears pin n's latch. A write with that bit at 0 leaves the latch unchanged, and a clear of one pin leaves the other pins' latches alone.
- R8: When a qualifying edge is detected in the same cycle as a clear write for that pin, the edge wins and the latch stays set.
- R9: A pin whose enable bit is 0 drives its request to 0. Its edge latch still captures edges, so setting the enable later exposes a pending edge.
- R10: While the master enable is 0, all four requests are 0 whatever the pin state. Setting it again forwards the requests that are pending.
- R11: In the level modes (0 and 3) the latch never sets. A pulse seen in level mode leaves no request after a later switch to an edge mode.
- R12: The output `crit_route` equals control bit 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pin_in | input | 4 | Asynchronous external interrupt pins, bit n is pin n |
| reg_wr | input | 1 | Control word write strobe |
| reg_wdata | input | 32 | Control word write data |
| reg_rdata | output | 32 | Control word read-back |
| req_out | output | 4 | Qualified request per pin, bit n is pin n |
| crit_route | output | 1 | Critical-interrupt normal routing select |

## Verification
The hardest case to reach from the ports is a clear write that lands in exactly the cycle in which the edge detector fires. That edge is only visible inside the block. The bench counts registers from the pin change: the first synchroniser stage captures at one edge and the second at the next, and the edge is then judged against the stored previous level. The bench drives the pin at a falling clock edge and waits two rising edges. It then asserts the clear write so that the write lands on the third rising edge, which is the same edge at which the latch sets. A repeat of the clear one cycle later then confirms that the clear path itself works.

// File: rtl/extint_pkg.sv
// Package: shared types and fixed layout for the external interrupt sense unit.
// Assumes a 32-bit control word and at most four pins in the layout below.
package extint_pkg;

    typedef enum logic [1:0] {
        SENSE_HIGH = 2'd0,
        SENSE_RISE = 2'd1,
        SENSE_FALL = 2'd2,
        SENSE_LOW  = 2'd3
    } sense_mode_e;

    localparam int CTRL_W     = 32;
    localparam int MODE_TOP   = 23;  // pin 0 mode msb; pin n at 23-2n
    localparam int CLR_TOP    = 27;  // pin 0 clear bit; pin n at 27-n
    localparam int EN_TOP     = 11;  // pin 0 enable; pin n at 11-n
    localparam int MASTER_BIT = 12;
    localparam int CRIT_BIT   = 0;

endpackage

// File: rtl/extint_sync.sv
// Module: multi-stage synchroniser for a bus of independent asynchronous bits.
// Assumes each bit is a slow level; no bus coherency is implied.
module extint_sync #(
    parameter int WIDTH  = 4,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);

    logic [WIDTH-1:0] stage_q [STAGES];

    // Shift the asynchronous inputs through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stage_q[i] <= '0;
        end else begin
            stage_q[0] <= async_in;
            for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
        end
    end

    assign sync_out = stage_q[STAGES-1];

endmodule

// File: rtl/extint_ctrl_reg.sv
// Module: control word storage and read-back for the sense unit.
// Assumes the fixed bit layout of extint_pkg; clear bits are decoded into
// one-cycle strobes and are never stored.
module extint_ctrl_reg
    import extint_pkg::*;
#(
    parameter int NUM_PINS = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr,
    input  logic [CTRL_W-1:0]      wdata,
    output logic [CTRL_W-1:0]      rdata,
    output sense_mode_e            mode   [NUM_PINS],
    output logic [NUM_PINS-1:0]    pin_en,
    output logic [NUM_PINS-1:0]    clr_stb,
    output logic                   master_en,
    output logic                   crit
);

    localparam logic [CTRL_W-1:0] ONE = {{(CTRL_W-1){1'b0}}, 1'b1};

    sense_mode_e            mode_q [NUM_PINS];
    logic [NUM_PINS-1:0]    en_q;
    logic                   master_q;
    logic                   crit_q;
    logic [CTRL_W-1:0]      used_mask;
    logic                   unused_wbits;

    // Store the configuration fields on a write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int n = 0; n < NUM_PINS; n++) mode_q[n] <= SENSE_HIGH;
            en_q     <= '0;
            master_q <= 1'b0;
            crit_q   <= 1'b0;
        end else if (wr) begin
            for (int n = 0; n < NUM_PINS; n++) begin
                mode_q[n] <= sense_mode_e'(wdata[MODE_TOP-2*n -: 2]);
                en_q[n]   <= wdata[EN_TOP-n];
            end
            master_q <= wdata[MASTER_BIT];
            crit_q   <= wdata[CRIT_BIT];
        end
    end

    // Assemble the read-back word; clear bits and spare bits read zero.
    always_comb begin
        rdata = '0;
        for (int n = 0; n < NUM_PINS; n++) begin
            rdata[MODE_TOP-2*n -: 2] = mode_q[n];
            rdata[EN_TOP-n]          = en_q[n];
        end
        rdata[MASTER_BIT] = master_q;
        rdata[CRIT_BIT]   = crit_q;
    end

    // Mark which write bits have a function, for the spare-bit sink.
    always_comb begin
        used_mask = (ONE << MASTER_BIT) | (ONE << CRIT_BIT);
        for (int n = 0; n < NUM_PINS; n++) begin
            used_mask = used_mask | (ONE << (MODE_TOP-2*n)) | (ONE << (MODE_TOP-2*n-1))
                      | (ONE << (EN_TOP-n)) | (ONE << (CLR_TOP-n));
        end
    end

    assign unused_wbits = ^(wdata & ~used_mask);

    genvar g;
    generate
        for (g = 0; g < NUM_PINS; g++) begin : g_clr
            assign clr_stb[g] = wr & wdata[CLR_TOP-g];
            assign mode[g]    = mode_q[g];
        end
    endgenerate

    assign pin_en    = en_q;
    assign master_en = master_q;
    assign crit      = crit_q;

    AST_RDATA_STABLE_NO_WR: assert property (@(posedge clk) disable iff (!rst_n)
        !wr |=> $stable(rdata)) else $error("read-back changed without write"); // R2

endmodule

// File: rtl/extint_detect.sv
// Module: per-pin level/edge detection, edge latch and request qualification.
// Assumes s_level is already synchronised; a set edge beats a same-cycle clear.
module extint_detect
    import extint_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        s_level,
    input  sense_mode_e mode,
    input  logic        clr,
    input  logic        en,
    input  logic        master_en,
    output logic        req
);

    logic prev_q;
    logic latch_q;
    logic edge_w;
    logic edge_mode_w;
    logic level_w;

    // Remember the previous synchronised level for edge comparison.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= s_level;
    end

    // Decode the selected sense mode into edge event and level state.
    always_comb begin
        edge_w      = 1'b0;
        edge_mode_w = 1'b0;
        level_w     = 1'b0;
        unique case (mode)
            SENSE_HIGH: level_w = s_level;
            SENSE_RISE: begin edge_mode_w = 1'b1; edge_w = s_level & ~prev_q; end
            SENSE_FALL: begin edge_mode_w = 1'b1; edge_w = ~s_level & prev_q; end
            SENSE_LOW:  level_w = ~s_level;
            default:    level_w = 1'b0;
        endcase
    end

    // Hold an edge until cleared; a new edge has precedence over the clear.
    always_ff @(posedge clk) begin
        if (!rst_n)      latch_q <= 1'b0;
        else if (edge_w) latch_q <= 1'b1;
        else if (clr)    latch_q <= 1'b0;
    end

    assign req = (edge_mode_w ? latch_q : level_w) & en & master_en;

    AST_EDGE_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_w && clr) |=> latch_q) else $error("clear beat edge"); // R8
    AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !edge_w) |=> !latch_q) else $error("clear ignored"); // R7
    AST_LATCH_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (latch_q && !clr) |=> latch_q) else $error("latch dropped"); // R5
    AST_LEVEL_NO_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (!edge_mode_w && !latch_q) |=> !latch_q) else $error("level mode latched"); // R11

endmodule

// File: rtl/extint_sense.sv
// Module: top of the external interrupt pin sense unit.
// Assumes pins are asynchronous to clk; outputs one qualified request per pin.
module extint_sense
    import extint_pkg::*;
#(
    parameter int NUM_PINS    = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] pin_in,
    input  logic                reg_wr,
    input  logic [CTRL_W-1:0]   reg_wdata,
    output logic [CTRL_W-1:0]   reg_rdata,
    output logic [NUM_PINS-1:0] req_out,
    output logic                crit_route
);

    logic [NUM_PINS-1:0] pin_sync;
    sense_mode_e         mode [NUM_PINS];
    logic [NUM_PINS-1:0] pin_en;
    logic [NUM_PINS-1:0] clr_stb;
    logic                master_en;

    extint_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pin_in),
        .sync_out (pin_sync)
    );

    extint_ctrl_reg #(.NUM_PINS(NUM_PINS)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr        (reg_wr),
        .wdata     (reg_wdata),
        .rdata     (reg_rdata),
        .mode      (mode),
        .pin_en    (pin_en),
        .clr_stb   (clr_stb),
        .master_en (master_en),
        .crit      (crit_route)
    );

    genvar g;
    generate
        for (g = 0; g < NUM_PINS; g++) begin : g_pin
            extint_detect u_det (
                .clk       (clk),
                .rst_n     (rst_n),
                .s_level   (pin_sync[g]),
                .mode      (mode[g]),
                .clr       (clr_stb[g]),
                .en        (pin_en[g]),
                .master_en (master_en),
                .req       (req_out[g])
            );
        end
    endgenerate

    AST_MASTER_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        !master_en |-> (req_out == '0)) else $error("request with master off"); // R10
    AST_ENABLE_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        (req_out & ~pin_en) == '0) else $error("request from disabled pin"); // R9

endmodule

// File: tb/tb_extint_sense.sv
// Directed bench for extint_sense: one task per scenario, each self-checking.
module tb_extint_sense;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  pin_in = '0;
    logic        reg_wr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [3:0]  req_out;
    logic        crit_route;

    int n_checks = 0;
    int n_fail   = 0;

    always #5 clk = ~clk;

    extint_sense dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .pin_in     (pin_in),
        .reg_wr     (reg_wr),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .req_out    (req_out),
        .crit_route (crit_route)
    );

    // Build a control word; m and e are indexed by pin number.
    function automatic logic [31:0] cfg(input logic [1:0] m0, input logic [1:0] m1,
                                        input logic [1:0] m2, input logic [1:0] m3,
                                        input logic [3:0] e, input logic mst,
                                        input logic crt);
        cfg = {4'b0, m0, m1, m2, m3, 3'b0, mst, e[0], e[1], e[2], e[3], 7'b0, crt};
    endfunction

    function automatic logic [31:0] clr_bits(input logic [3:0] p);
        clr_bits = {4'b0, p[0], p[1], p[2], p[3], 24'b0};
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    task automatic setup(input logic [31:0] c, input logic [3:0] pins);
        wr(c);
        @(negedge clk); pin_in = pins;
        settle();
        wr(c | clr_bits(4'hF));
        settle();
    endtask

    task automatic t_reset();
        chk("R1 rdata", reg_rdata, 32'h0);
        chk("R1 req", {28'h0, req_out}, 32'h0);
        chk("R1 crit", {31'h0, crit_route}, 32'h0);
    endtask

    task automatic t_layout();
        wr(32'hFFFF_FFFF);
        chk("R2 all-ones readback", reg_rdata, 32'h00FF_1F01);
        chk("R12 crit set", {31'h0, crit_route}, 32'h1);
        wr(cfg(2'd1, 2'd2, 2'd3, 2'd0, 4'b0101, 1'b0, 1'b0));
        chk("R2 field readback", reg_rdata, 32'h006C_0A00);
        chk("R12 crit clear", {31'h0, crit_route}, 32'h0);
    endtask

    task automatic t_level_high();
        logic [31:0] c = cfg(2'd0, 2'd0, 2'd0, 2'd0, 4'hF, 1'b1, 1'b0);
        setup(c, 4'h0);
        chk("R3 idle", {28'h0, req_out}, 32'h0);
        @(negedge clk); pin_in = 4'b0001;
        @(negedge clk);
        chk("R3 one-cycle latency still low", {28'h0, req_out}, 32'h0);
        @(negedge clk);
        chk("R3 high after two clocks", {28'h0, req_out}, 32'h1);
        @(negedge clk); pin_in = 4'b0000;
        settle();
        chk("R3 drops with pin", {28'h0, req_out}, 32'h0);
    endtask

    task automatic t_level_low();
        logic [31:0] c = cfg(2'd0, 2'd3, 2'd0, 2'd0, 4'b0010, 1'b1, 1'b0);
        setup(c, 4'h0);
        chk("R4 active low asserted", {28'h0, req_out}, 32'h2);
        @(negedge clk); pin_in = 4'b0010;
        settle();
        chk("R4 high releases", {28'h0, req_out}, 32'h0);
        @(negedge clk); pin_in = 4'b0000;
        settle();
    endtask

    task automatic t_edges();
        logic [31:0] c = cfg(2'd0, 2'd0, 2'd1, 2'd2, 4'b1100, 1'b1, 1'b0);
        setup(c, 4'h0);
        @(negedge clk); pin_in = 4'b1100;
        settle();
        chk("R5/R6 rise latches pin2 only", {28'h0, req_out}, 32'h4);
        @(negedge clk); pin_in = 4'b0000;
        settle();
        chk("R5/R6 pin2 held, fall latches pin3", {28'h0, req_out}, 32'hC);
        wr(c);
        chk("R7 zero clear bits no effect", {28'h0, req_out}, 32'hC);
        wr(c | clr_bits(4'b0100));
        chk("R7 clear pin2 only", {28'h0, req_out}, 32'h8);
        wr(c | clr_bits(4'b1000));
        chk("R7 clear pin3", {28'h0, req_out}, 32'h0);
        @(negedge clk); pin_in = 4'b1000;
        settle();
        chk("R6 rise ignored in fall mode", {28'h0, req_out}, 32'h0);
        @(negedge clk); pin_in = 4'b0000;
        settle();
        wr(c | clr_bits(4'hF));
    endtask

    task automatic t_edge_wins();
        logic [31:0] c = cfg(2'd0, 2'd1, 2'd0, 2'd0, 4'b0010, 1'b1, 1'b0);
        setup(c, 4'h0);
        @(negedge clk); pin_in = 4'b0010;
        @(negedge clk);
        @(negedge clk);
        reg_wr = 1'b1; reg_wdata = c | clr_bits(4'b0010);
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0;
        settle();
        chk("R8 edge beats simultaneous clear", {28'h0, req_out}, 32'h2);
        wr(c | clr_bits(4'b0010));
        chk("R8 later clear removes", {28'h0, req_out}, 32'h0);
        @(negedge clk); pin_in = 4'b0000;
        settle();
    endtask

    task automatic t_gating();
        logic [31:0] c_off = cfg(2'd1, 2'd0, 2'd0, 2'd0, 4'b0000, 1'b1, 1'b0);
        logic [31:0] c_on  = cfg(2'd1, 2'd0, 2'd0, 2'd0, 4'b0001, 1'b1, 1'b0);
        logic [31:0] c_nm  = cfg(2'd1, 2'd0, 2'd0, 2'd0, 4'b0001, 1'b0, 1'b0);
        setup(c_off, 4'h0);
        @(negedge clk); pin_in = 4'b0001;
        settle();
        chk("R9 disabled pin silent", {28'h0, req_out}, 32'h0);
        wr(c_on);
        chk("R9 enable exposes pending edge", {28'h0, req_out}, 32'h1);
        wr(c_nm);
        chk("R10 master off blocks", {28'h0, req_out}, 32'h0);
        wr(c_on);
        chk("R10 master on restores", {28'h0, req_out}, 32'h1);
        wr(c_on | clr_bits(4'h1));
        @(negedge clk); pin_in = 4'b0000;
        settle();
    endtask

    task automatic t_level_no_latch();
        logic [31:0] c_lvl  = cfg(2'd0, 2'd0, 2'd0, 2'd0, 4'b0001, 1'b1, 1'b0);
        logic [31:0] c_edge = cfg(2'd1, 2'd0, 2'd0, 2'd0, 4'b0001, 1'b1, 1'b0);
        setup(c_lvl, 4'h0);
        @(negedge clk); pin_in = 4'b0001;
        settle();
        @(negedge clk); pin_in = 4'b0000;
        settle();
        wr(c_edge);
        chk("R11 level pulse left no latch", {28'h0, req_out}, 32'h0);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_layout();
        t_level_high();
        t_level_low();
        t_edges();
        t_edge_wins();
        t_gating();
        t_level_no_latch();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule